// File: doc/BRIEF.md
# Idle Power State Sequencer

This block steps a processor core through an idle period. Software issues a wait request that carries a depth hint, a wake-extension flag and the requester's privilege level. The block settles which state and sub-state to use, clamping the hint by privilege and by a per-core table of supported sub-states. It then counts down an entry latency, holds the idle state until a break event, counts down an exit latency and returns to the active state.

Timestamps from a free-running counter are captured on reaching idle and at the wake event, so that residency is known before any interrupt handling starts. A break event during entry aborts straight into exit. Requests that arrive while the sequence runs are dropped.

Top module: `idle_seq`

## Requirements
- R1: A request in the active state starts entry on the next clock edge: `busy_o` rises and `cstate_o` gives the chosen state number (1 = C1) and `substate_o` the chosen sub-state. In the active state `cstate_o` and `substate_o` are 0.
- R2: When `priv_i` is nonzero the block picks C1 with sub-state 0, whatever the hint holds.
- R3: The hint carries the state field in bits [7:4] (value + 1 = C-state number) and the sub-state in bits [3:0]. `sub_cnt_i[4*k+3:4*k]` is the number of legal sub-states of state field k, and 0 marks it unsupported; field 0 always counts as at least 1. A hint naming an unsupported or out-of-range state is lowered to the deepest supported state below it, and then takes that state's deepest sub-state. A sub-state beyond the count is lowered to the count minus one.
- R4: The chosen state is never deeper than the hint's state field.
- R5: Entry lasts `ENT_BASE + ENT_STEP*(c-1)` cycles and exit `EXT_BASE + EXT_STEP*(c-1)` cycles for state Cc.
- R6: A monitor write, or an interrupt with `int_en_i` high, ends the idle state. Break inputs have no effect while the block is active.
- R7: With `int_en_i` low, an interrupt ends the idle state only if the request carried `wake_ext_i` high and `wake_cap_i` is high; otherwise it is ignored.
- R8: A break event during entry moves the block to exit on the next edge without passing through idle, and the residency reads 0.
- R9: `entry_ts_o` takes `time_i` on the edge that reaches idle, `wake_ts_o` takes it on the break edge, and `resid_o` equals their difference with `resid_vld_o` high for exactly the first active cycle after exit.
- R10: A request while busy is ignored and leaves the chosen state and sub-state unchanged.
- R11: After reset the block is active with `busy_o`, `resid_vld_o`, both timestamps and the state outputs all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Wait request |
| hint_i | input | 8 | Depth hint: state [7:4], sub-state [3:0] |
| wake_ext_i | input | 1 | Extension flag: masked interrupt may wake |
| priv_i | input | 2 | Privilege level of the requester |
| sub_cnt_i | input | 4*N_ST | Legal sub-state count per state |
| wake_cap_i | input | 1 | Core supports masked-interrupt wake |
| int_en_i | input | 1 | Interrupts enabled |
| irq_i | input | 1 | Interrupt pending |
| mon_wr_i | input | 1 | Write seen on the monitored range |
| time_i | input | TS_W | Free-running time counter |
| cstate_o | output | 4 | Current C-state number, 0 when active |
| substate_o | output | 4 | Current sub-state |
| busy_o | output | 1 | Sequence in progress |
| idle_o | output | 1 | Idle state held |
| entry_ts_o | output | TS_W | Time at idle reached |
| wake_ts_o | output | TS_W | Time at break event |
| resid_o | output | TS_W | Idle residency |
| resid_vld_o | output | 1 | Residency valid, one cycle |

## Verification
The assertions assume `sub_cnt_i` stays constant while a sequence runs and that `time_i` advances by one per cycle without wrapping inside a sequence. The bench sets the table once, before any request, and drives the time counter from its own incrementing register. Break inputs change only on the falling clock edge, and one break source is used per vector.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int FLD_W = 4;
  localparam int HINT_W = 2 * FLD_W;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_ENTER  = 2'd1,
    PH_IDLE   = 2'd2,
    PH_EXIT   = 2'd3
  } phase_e;
endpackage

// File: rtl/idle_depth_clamp.sv
module idle_depth_clamp
  import idle_pkg::*;
#(
  parameter int N_ST = 4,
  localparam int ST_W = $clog2(N_ST)
) (
  input  logic [HINT_W-1:0]     hint_i,
  input  logic [1:0]            priv_i,
  input  logic [N_ST*FLD_W-1:0] sub_cnt_i,
  output logic [ST_W-1:0]       st_o,
  output logic [FLD_W-1:0]      sub_o
);
  logic [FLD_W-1:0] cnt_eff [N_ST];

  // state field 0 is always usable with at least one sub-state
  for (genvar g = 0; g < N_ST; g++) begin : g_cnt
    if (g == 0) begin : g_base
      assign cnt_eff[g] = (sub_cnt_i[FLD_W-1:0] == '0) ? FLD_W'(1) : sub_cnt_i[FLD_W-1:0];
    end else begin : g_rest
      assign cnt_eff[g] = sub_cnt_i[g*FLD_W +: FLD_W];
    end
  end

  int               req_st;
  int               lim;
  logic [FLD_W-1:0] max_sub;
  logic [FLD_W-1:0] hint_sub;

  assign hint_sub = hint_i[FLD_W-1:0];

  always_comb begin
    req_st  = int'(hint_i[HINT_W-1:FLD_W]);
    lim     = (req_st > N_ST - 1) ? N_ST - 1 : req_st;
    st_o    = '0;
    for (int i = 0; i < N_ST; i++) begin
      if (i <= lim && cnt_eff[i] != '0) st_o = ST_W'(i);
    end
    if (priv_i != '0) st_o = '0;
    max_sub = cnt_eff[st_o] - FLD_W'(1);
    if (priv_i != '0) begin
      sub_o = '0;
    end else if (int'(st_o) == req_st) begin
      sub_o = (hint_sub > max_sub) ? max_sub : hint_sub;
    end else begin
      sub_o = max_sub;
    end
  end

  always_comb begin
    if (priv_i == '0) begin
      AST_SUB_IN_TABLE: assert (sub_o < cnt_eff[st_o]); // R3
    end
  end
endmodule

// File: rtl/idle_break.sv
module idle_break (
  input  logic mon_wr_i,
  input  logic irq_i,
  input  logic int_en_i,
  input  logic ext_q_i,
  input  logic wake_cap_i,
  output logic brk_o
);
  logic masked_wake;

  assign masked_wake = irq_i & ~int_en_i & ext_q_i & wake_cap_i;
  assign brk_o       = mon_wr_i | (irq_i & int_en_i) | masked_wake;
endmodule

// File: rtl/idle_lat_timer.sv
module idle_lat_timer #(
  parameter int N_ST     = 4,
  parameter int CNT_W    = 8,
  parameter int ENT_BASE = 2,
  parameter int ENT_STEP = 3,
  parameter int EXT_BASE = 1,
  parameter int EXT_STEP = 2,
  localparam int ST_W    = $clog2(N_ST),
  localparam int ENT_MAX = ENT_BASE + ENT_STEP * (N_ST - 1),
  localparam int EXT_MAX = EXT_BASE + EXT_STEP * (N_ST - 1),
  localparam int LAT_MAX = (ENT_MAX > EXT_MAX) ? ENT_MAX : EXT_MAX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_ent_i,
  input  logic            load_ext_i,
  input  logic [ST_W-1:0] st_i,
  output logic            done_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] lat_m1(input int base, input int step,
                                                input logic [ST_W-1:0] s);
    return CNT_W'(base - 1) + CNT_W'(step) * CNT_W'(s);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_ent_i) begin
      cnt_q <= lat_m1(ENT_BASE, ENT_STEP, st_i);
    end else if (load_ext_i) begin
      cnt_q <= lat_m1(EXT_BASE, EXT_STEP, st_i);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LAT_MAX); // R5
  AST_CNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ent_i && !load_ext_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_pkg::*;
#(
  parameter int N_ST     = 4,
  parameter int TS_W     = 32,
  parameter int CNT_W    = 8,
  parameter int ENT_BASE = 2,
  parameter int ENT_STEP = 3,
  parameter int EXT_BASE = 1,
  parameter int EXT_STEP = 2,
  localparam int ST_W    = $clog2(N_ST)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [7:0]            hint_i,
  input  logic                  wake_ext_i,
  input  logic [1:0]            priv_i,
  input  logic [N_ST*4-1:0]     sub_cnt_i,
  input  logic                  wake_cap_i,
  input  logic                  int_en_i,
  input  logic                  irq_i,
  input  logic                  mon_wr_i,
  input  logic [TS_W-1:0]       time_i,
  output logic [3:0]            cstate_o,
  output logic [3:0]            substate_o,
  output logic                  busy_o,
  output logic                  idle_o,
  output logic [TS_W-1:0]       entry_ts_o,
  output logic [TS_W-1:0]       wake_ts_o,
  output logic [TS_W-1:0]       resid_o,
  output logic                  resid_vld_o
);
  phase_e           phase_q;
  logic [ST_W-1:0]  st_q;
  logic [FLD_W-1:0] sub_q;
  logic [FLD_W-1:0] hst_q;
  logic [1:0]       priv_q;
  logic             ext_q;
  logic [TS_W-1:0]  entry_ts_q;
  logic [TS_W-1:0]  wake_ts_q;
  logic             resid_vld_q;

  logic [ST_W-1:0]  cl_st;
  logic [FLD_W-1:0] cl_sub;
  logic             brk;
  logic             tmr_done;
  logic             accept;
  logic             load_ext;
  logic [ST_W-1:0]  tmr_st;

  idle_depth_clamp #(.N_ST(N_ST)) u_clamp (
    .hint_i    (hint_i),
    .priv_i    (priv_i),
    .sub_cnt_i (sub_cnt_i),
    .st_o      (cl_st),
    .sub_o     (cl_sub)
  );

  idle_break u_brk (
    .mon_wr_i   (mon_wr_i),
    .irq_i      (irq_i),
    .int_en_i   (int_en_i),
    .ext_q_i    (ext_q),
    .wake_cap_i (wake_cap_i),
    .brk_o      (brk)
  );

  assign accept   = (phase_q == PH_ACTIVE) && req_i;
  assign load_ext = ((phase_q == PH_ENTER) || (phase_q == PH_IDLE)) && brk;
  assign tmr_st   = accept ? cl_st : st_q;

  idle_lat_timer #(
    .N_ST     (N_ST),
    .CNT_W    (CNT_W),
    .ENT_BASE (ENT_BASE),
    .ENT_STEP (ENT_STEP),
    .EXT_BASE (EXT_BASE),
    .EXT_STEP (EXT_STEP)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_ent_i (accept),
    .load_ext_i (load_ext),
    .st_i       (tmr_st),
    .done_o     (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_ACTIVE;
      st_q        <= '0;
      sub_q       <= '0;
      hst_q       <= '0;
      priv_q      <= '0;
      ext_q       <= 1'b0;
      entry_ts_q  <= '0;
      wake_ts_q   <= '0;
      resid_vld_q <= 1'b0;
    end else begin
      resid_vld_q <= 1'b0;
      unique case (phase_q)
        PH_ACTIVE: begin
          if (req_i) begin
            phase_q <= PH_ENTER;
            st_q    <= cl_st;
            sub_q   <= cl_sub;
            hst_q   <= hint_i[7:4];
            priv_q  <= priv_i;
            ext_q   <= wake_ext_i;
          end
        end
        PH_ENTER: begin
          if (brk) begin
            // abort: zero residency
            phase_q    <= PH_EXIT;
            entry_ts_q <= time_i;
            wake_ts_q  <= time_i;
          end else if (tmr_done) begin
            phase_q    <= PH_IDLE;
            entry_ts_q <= time_i;
          end
        end
        PH_IDLE: begin
          if (brk) begin
            phase_q   <= PH_EXIT;
            wake_ts_q <= time_i;
          end
        end
        PH_EXIT: begin
          if (tmr_done) begin
            phase_q     <= PH_ACTIVE;
            resid_vld_q <= 1'b1;
          end
        end
        default: phase_q <= PH_ACTIVE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_ACTIVE);
  assign idle_o      = (phase_q == PH_IDLE);
  assign cstate_o    = busy_o ? (4'(st_q) + 4'd1) : 4'd0;
  assign substate_o  = busy_o ? sub_q : 4'd0;
  assign entry_ts_o  = entry_ts_q;
  assign wake_ts_o   = wake_ts_q;
  assign resid_o     = wake_ts_q - entry_ts_q;
  assign resid_vld_o = resid_vld_q;

  AST_DEPTH_LE_HINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(st_q) <= int'(hst_q))); // R4
  AST_PRIV_C1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && priv_q != '0) |-> (st_q == '0 && sub_q == '0)); // R2
  AST_ENTER_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ENTER && brk) |=> (phase_q == PH_EXIT)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !brk) |=> (phase_q == PH_IDLE)); // R6
  AST_RESID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resid_vld_q |=> !resid_vld_q); // R9
  AST_RESID_AFTER_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resid_vld_q) |-> ($past(phase_q) == PH_EXIT)); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> ($stable(st_q) && $stable(sub_q))); // R10
endmodule

// File: tb/idle_seq_tb.sv
module idle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  hint = '0;
  logic        wext = 1'b0;
  logic [1:0]  priv = '0;
  logic [15:0] sub_cnt = 16'h1302; // C1:2, C2:0, C3:3, C4:1
  logic        cap = 1'b1;
  logic        int_en = 1'b0;
  logic        irq = 1'b0;
  logic        mon = 1'b0;
  logic [31:0] tnow = '0;
  logic [3:0]  cst, sub;
  logic        busy, idle, rvld;
  logic [31:0] ets, wts, res;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(negedge clk) tnow <= tnow + 32'd1;

  idle_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .hint_i(hint), .wake_ext_i(wext),
    .priv_i(priv), .sub_cnt_i(sub_cnt), .wake_cap_i(cap), .int_en_i(int_en),
    .irq_i(irq), .mon_wr_i(mon), .time_i(tnow), .cstate_o(cst), .substate_o(sub),
    .busy_o(busy), .idle_o(idle), .entry_ts_o(ets), .wake_ts_o(wts),
    .resid_o(res), .resid_vld_o(rvld)
  );

  typedef struct packed {
    logic [1:0] priv;
    logic [7:0] hint;
    logic       ext;
    logic [1:0] kind; // 0 irq enabled, 1 monitor write, 2 masked irq
    logic [3:0] w;
    logic [3:0] cst;
    logic [3:0] sub;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 8'h01, 1'b0, 2'd0, 4'd3, 4'd1, 4'd1},
    '{2'd0, 8'h13, 1'b0, 2'd0, 4'd2, 4'd1, 4'd1},
    '{2'd0, 8'h22, 1'b0, 2'd1, 4'd4, 4'd3, 4'd2},
    '{2'd0, 8'h27, 1'b0, 2'd0, 4'd0, 4'd3, 4'd2},
    '{2'd0, 8'h35, 1'b0, 2'd0, 4'd5, 4'd4, 4'd0},
    '{2'd0, 8'hF0, 1'b0, 2'd1, 4'd1, 4'd4, 4'd0},
    '{2'd3, 8'h32, 1'b0, 2'd0, 4'd2, 4'd1, 4'd0},
    '{2'd1, 8'h00, 1'b0, 2'd1, 4'd3, 4'd1, 4'd0},
    '{2'd0, 8'h30, 1'b1, 2'd2, 4'd6, 4'd4, 4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] p, input logic [7:0] h, input logic e);
    @(negedge clk);
    req = 1'b1; priv = p; hint = h; wext = e;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 1;
    while (!idle && n < 64) begin
      @(negedge clk);
      if (!idle) n++;
    end
  endtask

  task automatic wait_active(output int n);
    n = 1;
    while (busy && n < 64) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic pulse_break(input logic [1:0] kind);
    case (kind)
      2'd0: begin int_en = 1'b1; irq = 1'b1; end
      2'd1: mon = 1'b1;
      default: begin int_en = 1'b0; irq = 1'b1; end
    endcase
    @(negedge clk);
    int_en = 1'b0; irq = 1'b0; mon = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 0);
    chk("R11 cstate", 32'(cst), 0);
    chk("R11 substate", 32'(sub), 0);
    chk("R11 resid_vld", 32'(rvld), 0);
    chk("R11 entry_ts", ets, 0);
    chk("R11 wake_ts", wts, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      int exp_ent = 2 + 3 * (int'(v.cst) - 1);
      int exp_ext = 1 + 2 * (int'(v.cst) - 1);
      issue(v.priv, v.hint, v.ext);
      chk("R1 busy after request", 32'(busy), 1);
      chk("R3 chosen state", 32'(cst), 32'(v.cst));
      chk("R3 chosen sub-state", 32'(sub), 32'(v.sub));
      chk("R4 depth not above hint", 32'(int'(cst) <= int'(v.hint[7:4]) + 1), 1);
      wait_idle(n);
      chk("R5 entry latency", 32'(n), 32'(exp_ent));
      repeat (v.w) @(negedge clk);
      pulse_break(v.kind);
      chk("R6 break leaves idle", 32'(idle), 0);
      wait_active(n);
      chk("R5 exit latency", 32'(n), 32'(exp_ext));
      chk("R9 resid_vld", 32'(rvld), 1);
      chk("R9 residency", res, 32'(v.w) + 1);
      @(negedge clk);
      chk("R9 resid_vld one cycle", 32'(rvld), 0);
    end

    // R2 explicit: privileged deep hint
    issue(2'd2, 8'h35, 1'b0);
    chk("R2 C1 forced", 32'(cst), 1);
    chk("R2 sub 0", 32'(sub), 0);
    wait_idle(n);
    pulse_break(2'd1);
    wait_active(n);

    // R6 break in active ignored
    pulse_break(2'd0);
    chk("R6 no start from break", 32'(busy), 0);

    // R7 masked irq without extension ignored
    issue(2'd0, 8'h00, 1'b0);
    wait_idle(n);
    int_en = 1'b0; irq = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 masked irq ignored", 32'(idle), 1);
    irq = 1'b0;
    pulse_break(2'd1);
    wait_active(n);

    // R7 extension set but capability low, then capability raised
    cap = 1'b0;
    issue(2'd0, 8'h00, 1'b1);
    wait_idle(n);
    int_en = 1'b0; irq = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 no capability ignored", 32'(idle), 1);
    cap = 1'b1;
    @(negedge clk);
    chk("R7 capability wakes", 32'(idle), 0);
    chk("R7 in exit", 32'(busy), 1);
    irq = 1'b0;
    wait_active(n);

    // R10 request while idle ignored
    issue(2'd0, 8'h22, 1'b0);
    wait_idle(n);
    issue(2'd0, 8'h00, 1'b0);
    chk("R10 state kept", 32'(cst), 3);
    chk("R10 sub kept", 32'(sub), 2);
    chk("R10 still idle", 32'(idle), 1);
    pulse_break(2'd0);
    wait_active(n);

    // R8 abort during entry
    issue(2'd0, 8'h20, 1'b0);
    pulse_break(2'd0);
    chk("R8 no idle", 32'(idle), 0);
    chk("R8 in exit", 32'(busy), 1);
    wait_active(n);
    chk("R8 exit latency", 32'(n), 5);
    chk("R8 resid_vld", 32'(rvld), 1);
    chk("R8 zero residency", res, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule